// File: doc/BRIEF.md
# Derandomizing Wilkinson Conversion Scheduler

This block sits behind one detector channel and lets it take new hits while earlier ones are still being digitized. It keeps a pool of four analogue hold buffers. Each hit claims the next buffer in rotation and records the value of a free-running coarse clock counter. A single counting converter is shared by two kinds of work on every buffer. The first is the fine-time interval, which spans from the hit to a clock edge one and a half periods later. The second is the held charge sample. The converter counts clock cycles from the start of a ramp until an external comparator reports that the ramp has crossed the held level. The comparator is modelled as the digital `ramp_done` input.

Conversions are granted strictly in arrival order, with the time conversion of a buffer ahead of its charge conversion. The charge result is reported in reverse sense, so a larger held signal gives a smaller code. The counter resolution can be set from 1 to 10 bits. A ramp that never trips the comparator saturates and is flagged. Finished events leave through a valid/ready port in time order. A buffer returns to the pool only once its event has been taken. Hits that find every buffer occupied are dropped and counted.

Top module: `wk_derand_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `conv_active`, `ramp_start` and `pool_full` are 0 and `lost_count` is 0.
- R2: The coarse counter is 0 at the first rising edge after reset and increments at every rising edge, wrapping at 2^TS_W. A hit accepted at an edge stores the counter value present at that edge, and that value is reported as `out_tstamp`.
- R3: Accepted hits take buffers in the rotating order 0, 1, 2, 3, 0, and so on. `out_buf` reports the buffer that held the event.
- R4: `pool_full` is 1 whenever all four buffers are occupied. A buffer is occupied from its hit until its event is taken. A hit that arrives while `pool_full` is 1 is dropped. Each dropped hit increments `lost_count`, which saturates at 255. Without a hit, `lost_count` holds its value.
- R5: Conversions run in hit order. Each buffer is converted first for time (`conv_kind`=0) and then for charge (`conv_kind`=1), and `conv_buf` names the buffer. `ramp_start` pulses in the idle cycle that precedes a conversion, and `conv_active` is 1 from the next cycle. At least one idle cycle separates two conversions.
- R6: If `ramp_done` is first sampled high in the k-th active cycle of a conversion, counting from 0, the raw count is k.
- R7: The resolution N comes from `cfg_res`, limited to the range 1 to 10: a value of 0 gives 1 and values above 10 give 10. N is captured when a conversion starts, and later changes do not affect that conversion. A conversion lasts at most 2^N active cycles.
- R8: If `ramp_done` stays low for all 2^N active cycles, the raw count saturates at 2^N-1 and the matching saturation flag (`out_fine_sat` or `out_charge_sat`) is 1. When `ramp_done` arrives in the last cycle, the result is 2^N-1 with the flag 0.
- R9: `out_fine` equals the raw count. `out_charge` equals (2^N-1) minus the raw count, so a saturated charge conversion reports 0.
- R10: Events leave in hit order. While `out_valid` is 1 and `out_ready` is 0, all output fields hold their values. An event is taken, and its buffer freed, on a rising edge where both are 1.
- R11: `ramp_done` has no effect while no conversion is active. No conversion starts and no event appears unless a hit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_res | input | 4 | Converter resolution in bits (limited to 1..10) |
| hit | input | 1 | Hit flag from the discriminator, one cycle per hit |
| ramp_done | input | 1 | Comparator output that ends the running ramp |
| ramp_start | output | 1 | Pulses in the cycle before a ramp begins |
| conv_active | output | 1 | The ramp counter is running |
| conv_kind | output | 1 | 0: time conversion, 1: charge conversion |
| conv_buf | output | 2 | Buffer being converted |
| pool_full | output | 1 | All buffers are occupied |
| lost_count | output | 8 | Saturating count of dropped hits |
| out_valid | output | 1 | An event is offered |
| out_ready | input | 1 | The consumer takes the offered event |
| out_buf | output | 2 | Buffer index of the event |
| out_tstamp | output | 12 | Coarse timestamp of the event |
| out_fine | output | 10 | Fine-time code |
| out_fine_sat | output | 1 | Fine-time ramp timed out |
| out_charge | output | 10 | Charge code (reverse sense) |
| out_charge_sat | output | 1 | Charge ramp timed out |

## Verification
The hardest state to reach is a pool that stays full while conversions finish behind it. In that state, output back-pressure alone has to keep hits being refused, and the loss counter has to climb to its ceiling and stay there. The bench withholds `out_ready` after a burst of hits. It then keeps firing more than 255 further hits into the full pool before it drains the events and checks their order. A comparator model answers each ramp after a chosen delay. Sweeping that delay through every count up to two beyond the full-scale value at small resolutions hits the boundary between "done in the last cycle" and timeout exactly.

// File: rtl/wk_pkg.sv
package wk_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int WK_MAX_RES = 10;
    localparam int WK_RES_W   = 4;

    typedef logic [WK_MAX_RES-1:0] wk_code_t;

    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_WAIT_T = 2'd1,
        SLOT_WAIT_Q = 2'd2,
        SLOT_READY  = 2'd3
    } wk_slot_e;

    typedef struct packed {
        wk_code_t code;
        logic     sat;
    } wk_result_t;

    // Limit a requested resolution to the supported range.
    function automatic logic [WK_RES_W-1:0] wk_clamp_res(input logic [WK_RES_W-1:0] r);
        if (r == '0)
            return {{(WK_RES_W-1){1'b0}}, 1'b1};
        else if (int'(r) > WK_MAX_RES)
            return WK_RES_W'(WK_MAX_RES);
        else
            return r;
    endfunction

    // Full-scale count (2^n - 1) for a resolution of n bits.
    function automatic wk_code_t wk_mask(input logic [WK_RES_W-1:0] n);
        wk_code_t m;
        m = '0;
        for (int i = 0; i < WK_MAX_RES; i++)
            if (i < int'(n)) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/wk_stamp_counter.sv
module wk_stamp_counter #(
    parameter int TS_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] stamp
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [TS_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign stamp = cnt_q;
endmodule

// File: rtl/wk_ramp_counter.sv
module wk_ramp_counter
    import wk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [WK_RES_W-1:0] res_in,
    input  logic                ramp_done,
    output logic                active,
    output logic                finish,
    output wk_result_t          result,
    output wk_code_t            mask_cur
);
    timeunit 1ns;
    timeprecision 100ps;

    logic     active_q;
    wk_code_t cnt_q;
    wk_code_t mask_q;

    // Ends on the comparator or when the full-scale count is reached.
    assign finish = active_q && (ramp_done || (cnt_q == mask_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            mask_q   <= '0;
        end else if (!active_q) begin
            if (start) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
                mask_q   <= wk_mask(wk_clamp_res(res_in));
            end
        end else if (finish) begin
            active_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        result.code = ramp_done ? cnt_q : mask_q;
        result.sat  = !ramp_done;
    end

    assign active   = active_q;
    assign mask_cur = mask_q;
endmodule

// File: rtl/wk_hold_pool.sv
module wk_hold_pool
    import wk_pkg::*;
#(
    parameter int NBUF   = 4,
    parameter int TS_W   = 12,
    parameter int LOST_W = 8,
    localparam int IDX_W = $clog2(NBUF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [TS_W-1:0]   stamp,
    input  logic              cv_fin,
    input  wk_result_t        cv_res,
    input  logic              pop,
    output logic              full,
    output logic              cv_pend,
    output logic              cv_kind,
    output logic [IDX_W-1:0]  cv_idx,
    output logic              rd_valid,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [TS_W-1:0]   rd_stamp,
    output wk_result_t        rd_fine,
    output wk_result_t        rd_charge,
    output logic [LOST_W-1:0] lost
);
    timeunit 1ns;
    timeprecision 100ps;

    wk_slot_e          st_q   [NBUF];
    logic [TS_W-1:0]   ts_q   [NBUF];
    wk_result_t        fine_q [NBUF];
    wk_result_t        chg_q  [NBUF];
    logic [IDX_W-1:0]  wr_q, cv_q, rd_q;
    logic [LOST_W-1:0] lost_q;

    logic accept, take, cv_last;

    function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(NBUF-1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (st_q[wr_q] != SLOT_FREE);
    assign accept   = hit && !full;
    assign rd_valid = (st_q[rd_q] == SLOT_READY);
    assign take     = pop && rd_valid;
    assign cv_pend  = (st_q[cv_q] == SLOT_WAIT_T) || (st_q[cv_q] == SLOT_WAIT_Q);
    assign cv_kind  = (st_q[cv_q] == SLOT_WAIT_Q);
    assign cv_last  = cv_fin && (st_q[cv_q] == SLOT_WAIT_Q);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= '0;
            cv_q   <= '0;
            rd_q   <= '0;
            lost_q <= '0;
            for (int i = 0; i < NBUF; i++) st_q[i] <= SLOT_FREE;
        end else begin
            if (accept)  wr_q <= nxt(wr_q);
            if (cv_last) cv_q <= nxt(cv_q);
            if (take)    rd_q <= nxt(rd_q);
            if (hit && full && (lost_q != '1)) lost_q <= lost_q + 1'b1;
            for (int i = 0; i < NBUF; i++) begin
                if (accept && (wr_q == IDX_W'(i))) begin
                    st_q[i] <= SLOT_WAIT_T;
                    ts_q[i] <= stamp;
                end else if (cv_fin && (cv_q == IDX_W'(i))) begin
                    if (st_q[i] == SLOT_WAIT_T) begin
                        st_q[i]   <= SLOT_WAIT_Q;
                        fine_q[i] <= cv_res;
                    end else begin
                        st_q[i]  <= SLOT_READY;
                        chg_q[i] <= cv_res;
                    end
                end else if (take && (rd_q == IDX_W'(i))) begin
                    st_q[i] <= SLOT_FREE;
                end
            end
        end
    end

    assign cv_idx    = cv_q;
    assign rd_idx    = rd_q;
    assign rd_stamp  = ts_q[rd_q];
    assign rd_fine   = fine_q[rd_q];
    assign rd_charge = chg_q[rd_q];
    assign lost      = lost_q;
endmodule

// File: rtl/wk_derand_sched.sv
module wk_derand_sched
    import wk_pkg::*;
#(
    parameter int NBUF   = 4,
    parameter int TS_W   = 12,
    parameter int LOST_W = 8,
    localparam int IDX_W = $clog2(NBUF)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [WK_RES_W-1:0] cfg_res,
    input  logic                hit,
    input  logic                ramp_done,
    output logic                ramp_start,
    output logic                conv_active,
    output logic                conv_kind,
    output logic [IDX_W-1:0]    conv_buf,
    output logic                pool_full,
    output logic [LOST_W-1:0]   lost_count,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [IDX_W-1:0]    out_buf,
    output logic [TS_W-1:0]     out_tstamp,
    output logic [WK_MAX_RES-1:0] out_fine,
    output logic                out_fine_sat,
    output logic [WK_MAX_RES-1:0] out_charge,
    output logic                out_charge_sat
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [TS_W-1:0] stamp;
    logic            active, fin, cv_pend, cv_kind;
    wk_result_t      raw_res, wr_res, rd_fine, rd_charge;
    wk_code_t        mask_cur;

    wk_stamp_counter #(.TS_W(TS_W)) u_stamp (
        .clk   (clk),
        .rst   (rst),
        .stamp (stamp)
    );

    // Grant: the oldest buffer with pending work gets the converter.
    assign ramp_start = !active && cv_pend;

    wk_ramp_counter u_ramp (
        .clk       (clk),
        .rst       (rst),
        .start     (ramp_start),
        .res_in    (cfg_res),
        .ramp_done (ramp_done),
        .active    (active),
        .finish    (fin),
        .result    (raw_res),
        .mask_cur  (mask_cur)
    );

    // Charge codes are reported in reverse sense.
    always_comb begin
        wr_res = raw_res;
        if (cv_kind) wr_res.code = mask_cur - raw_res.code;
    end

    wk_hold_pool #(.NBUF(NBUF), .TS_W(TS_W), .LOST_W(LOST_W)) u_pool (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .stamp     (stamp),
        .cv_fin    (fin),
        .cv_res    (wr_res),
        .pop       (out_ready),
        .full      (pool_full),
        .cv_pend   (cv_pend),
        .cv_kind   (cv_kind),
        .cv_idx    (conv_buf),
        .rd_valid  (out_valid),
        .rd_idx    (out_buf),
        .rd_stamp  (out_tstamp),
        .rd_fine   (rd_fine),
        .rd_charge (rd_charge),
        .lost      (lost_count)
    );

    assign conv_active    = active;
    assign conv_kind      = cv_kind;
    assign out_fine       = rd_fine.code;
    assign out_fine_sat   = rd_fine.sat;
    assign out_charge     = rd_charge.code;
    assign out_charge_sat = rd_charge.sat;
endmodule

// File: rtl/wk_derand_sched_chk.sv
module wk_derand_sched_chk #(
    parameter int TS_W   = 12,
    parameter int LOST_W = 8,
    parameter int IDX_W  = 2,
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              hit,
    input logic              ramp_start,
    input logic              conv_active,
    input logic              pool_full,
    input logic [LOST_W-1:0] lost_count,
    input logic              out_valid,
    input logic              out_ready,
    input logic [IDX_W-1:0]  out_buf,
    input logic [TS_W-1:0]   out_tstamp,
    input logic [CODE_W-1:0] out_fine,
    input logic [CODE_W-1:0] out_charge
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int MAX_LEN = 1 << CODE_W;

    logic [CODE_W:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)              run_len <= '0;
        else if (conv_active) run_len <= run_len + 1'b1;
        else                  run_len <= '0;
    end

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_buf) && $stable(out_tstamp)
                                    && $stable(out_fine) && $stable(out_charge));

    assert_drop_count_R4: assert property (@(posedge clk) disable iff (rst)
        hit && pool_full && (lost_count != '1) |=> lost_count == $past(lost_count) + 1'b1);

    assert_lost_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(lost_count));

    assert_start_active_R5: assert property (@(posedge clk) disable iff (rst)
        ramp_start |=> conv_active);

    assert_conv_len_R7: assert property (@(posedge clk) disable iff (rst)
        conv_active |-> (int'(run_len) < MAX_LEN));

    assert_idle_stays_R11: assert property (@(posedge clk) disable iff (rst)
        !conv_active && !ramp_start |=> !conv_active);
endmodule

bind wk_derand_sched wk_derand_sched_chk #(
    .TS_W(TS_W), .LOST_W(LOST_W), .IDX_W(IDX_W), .CODE_W(wk_pkg::WK_MAX_RES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hit         (hit),
    .ramp_start  (ramp_start),
    .conv_active (conv_active),
    .pool_full   (pool_full),
    .lost_count  (lost_count),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_buf     (out_buf),
    .out_tstamp  (out_tstamp),
    .out_fine    (out_fine),
    .out_charge  (out_charge)
);

// File: tb/tb_wk_derand_sched.sv
module tb_wk_derand_sched;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int TS_W = 12;

    typedef struct packed {
        int stamp; int fd; int cd; int rf; int rq; int idx;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_res = 4'd3;
    logic        hit = 1'b0;
    logic        ramp_done;
    logic        ramp_start, conv_active, conv_kind, pool_full;
    logic [1:0]  conv_buf, out_buf;
    logic [7:0]  lost_count;
    logic        out_valid, out_ready;
    logic [TS_W-1:0] out_tstamp;
    logic [9:0]  out_fine, out_charge;
    logic        out_fine_sat, out_charge_sat;

    logic force_done = 1'b0, resp_done = 1'b0;
    logic tgl_mode = 1'b0, tgl = 1'b0, rdy_lvl = 1'b1;
    assign ramp_done = force_done | resp_done;
    assign out_ready = tgl_mode ? tgl : rdy_lvl;

    always #2.5 clk = ~clk;

    wk_derand_sched dut (
        .clk(clk), .rst(rst), .cfg_res(cfg_res), .hit(hit), .ramp_done(ramp_done),
        .ramp_start(ramp_start), .conv_active(conv_active), .conv_kind(conv_kind),
        .conv_buf(conv_buf), .pool_full(pool_full), .lost_count(lost_count),
        .out_valid(out_valid), .out_ready(out_ready), .out_buf(out_buf),
        .out_tstamp(out_tstamp), .out_fine(out_fine), .out_fine_sat(out_fine_sat),
        .out_charge(out_charge), .out_charge_sat(out_charge_sat)
    );

    int checks = 0, bad = 0;
    int edges = 0, alloc_cnt = 0, exp_lost = 0, conv_cnt = 0;
    ev_t expq[$];
    int  delq[$];
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_res(input int r);
        if (r < 1) return 1;
        if (r > 10) return 10;
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    // Comparator model: fires after the delay queued for this conversion.
    int  rc = 0;
    bit  prev_act = 0;
    always @(negedge clk) begin
        if (conv_active) begin
            if (!prev_act) begin
                chk(int'(conv_kind) == conv_cnt % 2, "R5", "conv_kind", int'(conv_kind), conv_cnt % 2);
                chk(int'(conv_buf) == (conv_cnt / 2) % 4, "R5", "conv_buf", int'(conv_buf), (conv_cnt / 2) % 4);
            end
            resp_done = (delq.size() > 0) && (rc == delq[0]);
            rc++;
        end else begin
            resp_done = 1'b0;
            if (prev_act) begin
                if (delq.size() > 0) void'(delq.pop_front());
                conv_cnt++;
            end
            rc = 0;
        end
        prev_act = conv_active;
    end

    always @(negedge clk) if (tgl_mode) tgl = ~tgl;

    // Output monitor, sampled after the negedge drivers have settled.
    bit stall_prev = 0;
    int s_buf, s_ts, s_f, s_q;
    always @(negedge clk) begin
        #1;
        if (!rst && out_valid) begin
            if (stall_prev) begin
                chk(int'(out_buf) == s_buf && int'(out_tstamp) == s_ts && int'(out_fine) == s_f
                    && int'(out_charge) == s_q, "R10", "hold under stall", int'(out_tstamp), s_ts);
            end
            if (out_ready) begin
                if (expq.size() == 0) begin
                    chk(0, "R10", "unexpected event", int'(out_tstamp), -1);
                end else begin
                    ev_t e;
                    int mf, mq, ef, rq;
                    e  = expq.pop_front();
                    mf = (1 << eff_res(e.rf)) - 1;
                    mq = (1 << eff_res(e.rq)) - 1;
                    ef = (e.fd > mf) ? mf : e.fd;
                    rq = (e.cd > mq) ? mq : e.cd;
                    chk(int'(out_buf) == e.idx, "R3", "out_buf", int'(out_buf), e.idx);
                    chk(int'(out_tstamp) == e.stamp, "R2", "out_tstamp", int'(out_tstamp), e.stamp);
                    chk(int'(out_fine) == ef, "R6", "out_fine", int'(out_fine), ef);
                    chk(out_fine_sat == (e.fd > mf), "R8", "out_fine_sat", int'(out_fine_sat), int'(e.fd > mf));
                    chk(int'(out_charge) == mq - rq, "R9", "out_charge", int'(out_charge), mq - rq);
                    chk(out_charge_sat == (e.cd > mq), "R8", "out_charge_sat", int'(out_charge_sat), int'(e.cd > mq));
                end
            end
            stall_prev = !out_ready;
            s_buf = int'(out_buf); s_ts = int'(out_tstamp); s_f = int'(out_fine); s_q = int'(out_charge);
        end else begin
            stall_prev = 0;
        end
    end

    task automatic do_hit(input int fd, input int cd, input int rf, input int rq);
        ev_t e;
        @(negedge clk);
        hit = 1'b1;
        if (expq.size() < 4) begin
            e.stamp = edges % (1 << TS_W);
            e.fd = fd; e.cd = cd; e.rf = rf; e.rq = rq;
            e.idx = alloc_cnt % 4;
            alloc_cnt++;
            expq.push_back(e);
            delq.push_back(fd);
            delq.push_back(cd);
        end else if (exp_lost < 255) begin
            exp_lost++;
        end
        @(negedge clk);
        hit = 1'b0;
    endtask

    task automatic wait_empty();
        int n = 0;
        while (expq.size() != 0 && n < 30000) begin
            @(negedge clk);
            n++;
        end
        chk(expq.size() == 0, "R10", "drain", expq.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #900000;
        if (!finished) begin
            bad++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!out_valid && !conv_active && !pool_full && lost_count == 0, "R1", "in reset",
            int'(out_valid) + int'(conv_active) + int'(pool_full), 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(!out_valid && !conv_active && !ramp_start && !pool_full, "R1", "after reset",
            int'(out_valid) + int'(conv_active) + int'(ramp_start), 0);
        chk(lost_count == 0, "R1", "lost_count", int'(lost_count), 0);

        // R6 R8 R9: sweep every delay to two beyond full scale; R7 clamp of 0 to 1 bit
        for (int r = 0; r <= 3; r++) begin
            int m;
            cfg_res = 4'(r);
            m = (1 << eff_res(r)) - 1;
            for (int d = 0; d <= m + 2; d++) begin
                do_hit(d, m + 2 - d, r, r);
                wait_empty();
            end
        end

        // R7: clamp above 10 and full 10-bit range, exact last-cycle finish and timeout
        cfg_res = 4'd15;
        do_hit(1023, 1100, 15, 15);
        wait_empty();

        // R7: resolution captured at start; change during the time conversion
        cfg_res = 4'd3;
        do_hit(9, 9, 3, 10);
        while (!conv_active) @(negedge clk);
        cfg_res = 4'd10;
        wait_empty();

        // R11: comparator activity while idle
        force_done = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            #1;
            chk(!conv_active && !out_valid && !ramp_start, "R11", "idle ramp_done",
                int'(conv_active) + int'(out_valid), 0);
        end
        @(negedge clk);
        force_done = 1'b0;

        // R4 R10: burst into a stalled output
        cfg_res = 4'd4;
        rdy_lvl = 1'b0;
        do_hit(3, 20, 4, 4);
        do_hit(0, 15, 4, 4);
        do_hit(16, 1, 4, 4);
        do_hit(7, 7, 4, 4);
        #1;
        chk(pool_full == 1'b1, "R4", "pool_full", int'(pool_full), 1);
        do_hit(2, 2, 4, 4);
        do_hit(1, 1, 4, 4);
        repeat (200) @(negedge clk);
        #1;
        chk(int'(lost_count) == exp_lost, "R4", "lost_count", int'(lost_count), exp_lost);
        chk(out_valid == 1'b1, "R10", "stalled valid", int'(out_valid), 1);
        for (int i = 0; i < 260; i++) do_hit(1, 1, 4, 4);
        #1;
        chk(int'(lost_count) == 255, "R4", "lost saturation", int'(lost_count), 255);
        @(negedge clk);
        rdy_lvl = 1'b1;
        wait_empty();
        #1;
        chk(pool_full == 1'b0, "R4", "pool_full after drain", int'(pool_full), 0);
        chk(int'(lost_count) == 255, "R4", "lost hold", int'(lost_count), 255);

        // R3 R5 R10: alternating ready with closely spaced hits
        cfg_res = 4'd2;
        tgl_mode = 1'b1;
        do_hit(1, 2, 2, 2);
        do_hit(3, 0, 2, 2);
        do_hit(5, 4, 2, 2);
        do_hit(2, 6, 2, 2);
        do_hit(0, 1, 2, 2);
        wait_empty();
        tgl_mode = 1'b0;

        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule